// File: doc/BRIEF.md
# Int8 Matrix Multiply-Accumulate Unit

This unit carries out a byte-matrix multiply-accumulate over a vector register that is split into 128-bit segments. In each segment the first source holds a 2x8 matrix of bytes (row i is bytes 8i..8i+7), the second source holds another 2x8 matrix of bytes (row j is bytes 8j..8j+7), and the accumulator holds a 2x2 matrix of 32-bit lanes. Lane 2i+j of the segment receives the eight-term dot product of first-source row i with second-source row j, added to its previous value.

The unit accepts a 32-bit instruction word with a start pulse. It checks that the word belongs to the matrix-multiply group and reads the operand signedness from bits 23:22. Words outside the group, and the reserved signedness code, raise a one-cycle undefined flag. A legal word makes the unit busy for one cycle per segment, and it writes one segment of the result per cycle. The caller holds the source and accumulator buses steady while the unit is busy. Register storage belongs to the surrounding pipeline: the unit only reports the three register indices it decoded.

Top module: `i8mm_unit`

## Requirements
- R1: A word is in the group only when bits 31:29 = 010, bit 24 = 1, bit 21 = 0, bits 15:14 = 10 and bits 13:10 = 0110. On a start with any other word, undef_o is high for the one cycle after the start edge, the unit does not go busy and res_o is unchanged.
- R2: When a legal word is accepted, zda_o takes bits 4:0, zn_o takes bits 9:5 and zm_o takes bits 20:16.
- R3: Bits 23:22 = 00 treats the bytes of both sources as signed.
- R4: Bits 23:22 = 10 treats the first-source bytes as unsigned and the second-source bytes as signed.
- R5: Bits 23:22 = 11 treats the bytes of both sources as unsigned.
- R6: Bits 23:22 = 01 is reserved. It raises undef_o and leaves every result lane unchanged.
- R7: In segment s, lane 2i+j (bits s*128+32*(2i+j) +: 32) equals acc lane plus the sum over k=0..7 of A byte 8i+k times B byte 8j+k. Byte n of a segment is at bits 8n+7:8n.
- R8: Accumulation adds to the incoming accumulator lane and wraps modulo 2^32, with no saturation.
- R9: After the start edge of a legal word, one segment is written per clock. done_o is high for exactly one cycle, and it first appears VLEN/128 cycles after the start edge, with busy_o low.
- R10: A start while busy_o is high is ignored. It does not change the variant, the indices or the result, and it raises no undef_o.
- R11: After reset, busy_o, done_o and undef_o are low and res_o is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request with the instruction word |
| insn_i | input | 32 | Instruction word |
| src_a_i | input | VLEN | First source vector (2x8 byte matrices) |
| src_b_i | input | VLEN | Second source vector (2x8 byte matrices) |
| acc_i | input | VLEN | Accumulator input vector (2x2 32-bit lanes) |
| busy_o | output | 1 | Segments are being processed |
| done_o | output | 1 | One-cycle pulse after the last segment |
| undef_o | output | 1 | One-cycle pulse for an undefined word |
| res_o | output | VLEN | Result vector |
| zda_o | output | 5 | Decoded destination/accumulator index |
| zn_o | output | 5 | Decoded first source index |
| zm_o | output | 5 | Decoded second source index |

## Verification
The assertions assume that start_i is a single-cycle pulse from the caller. They also assume that the operand buses stay steady while busy_o is high, because each segment is read from them in its own cycle. The bench drives start for one cycle only and changes the operands only while the unit is idle. The one exception is the test that pulses start during a run; in that test the bench changes only the instruction word, so the run's result stays defined.

// File: rtl/i8mm_pkg.sv
package i8mm_pkg;
  localparam int SEG_W  = 128;
  localparam int ROWS   = 2;
  localparam int COLS   = 2;
  localparam int DEPTH  = 8;
  localparam int LANE_W = 32;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    MM_SS  = 2'b00,
    MM_RSV = 2'b01,
    MM_US  = 2'b10,
    MM_UU  = 2'b11
  } mm_var_e;
endpackage

// File: rtl/i8mm_decode.sv
module i8mm_decode
  import i8mm_pkg::*;
(
  input  logic [31:0] insn_i,
  output logic        legal_o,
  output logic        a_signed_o,
  output logic        b_signed_o,
  output logic [4:0]  zda_o,
  output logic [4:0]  zn_o,
  output logic [4:0]  zm_o
);
  mm_var_e var_w;
  logic    grp_hit;
  logic    unused_bits;

  assign var_w   = mm_var_e'(insn_i[23:22]);
  assign grp_hit = (insn_i[31:29] == 3'b010) && insn_i[24] && !insn_i[21] &&
                   (insn_i[15:14] == 2'b10) && (insn_i[13:10] == 4'b0110);

  assign legal_o    = grp_hit && (var_w != MM_RSV);
  assign a_signed_o = (var_w == MM_SS);
  assign b_signed_o = (var_w != MM_UU);
  assign zda_o      = insn_i[4:0];
  assign zn_o       = insn_i[9:5];
  assign zm_o       = insn_i[20:16];
  assign unused_bits = ^insn_i[28:25];
endmodule

// File: rtl/i8mm_dot.sv
module i8mm_dot
  import i8mm_pkg::*;
#(
  parameter int N = DEPTH
) (
  input  logic [N*BYTE_W-1:0] a_row_i,
  input  logic [N*BYTE_W-1:0] b_row_i,
  input  logic                a_signed_i,
  input  logic                b_signed_i,
  input  logic [LANE_W-1:0]   acc_i,
  output logic [LANE_W-1:0]   sum_o
);
  localparam int EXT_W  = BYTE_W + 1;
  localparam int PROD_W = 2 * EXT_W;

  logic signed [PROD_W-1:0] prod [N];

  for (genvar k = 0; k < N; k++) begin : g_prod
    logic signed [EXT_W-1:0] ea, eb;
    logic [BYTE_W-1:0] ab, bb;
    assign ab = a_row_i[k*BYTE_W +: BYTE_W];
    assign bb = b_row_i[k*BYTE_W +: BYTE_W];
    // extension bit picks signed or unsigned reading of the byte
    assign ea = {a_signed_i & ab[BYTE_W-1], ab};
    assign eb = {b_signed_i & bb[BYTE_W-1], bb};
    assign prod[k] = ea * eb;
  end

  always_comb begin
    sum_o = acc_i;
    for (int k = 0; k < N; k++) begin
      sum_o = sum_o + {{(LANE_W-PROD_W){prod[k][PROD_W-1]}}, prod[k]};
    end
  end
endmodule

// File: rtl/i8mm_seg.sv
module i8mm_seg
  import i8mm_pkg::*;
(
  input  logic [SEG_W-1:0] a_i,
  input  logic [SEG_W-1:0] b_i,
  input  logic [SEG_W-1:0] acc_i,
  input  logic             a_signed_i,
  input  logic             b_signed_i,
  output logic [SEG_W-1:0] res_o
);
  localparam int ROW_W = DEPTH * BYTE_W;

  for (genvar i = 0; i < ROWS; i++) begin : g_row
    for (genvar j = 0; j < COLS; j++) begin : g_col
      localparam int E = i * COLS + j;
      i8mm_dot #(.N(DEPTH)) u_dot (
        .a_row_i   (a_i[i*ROW_W +: ROW_W]),
        .b_row_i   (b_i[j*ROW_W +: ROW_W]),
        .a_signed_i(a_signed_i),
        .b_signed_i(b_signed_i),
        .acc_i     (acc_i[E*LANE_W +: LANE_W]),
        .sum_o     (res_o[E*LANE_W +: LANE_W])
      );
    end
  end
endmodule

// File: rtl/i8mm_unit.sv
module i8mm_unit
  import i8mm_pkg::*;
#(
  parameter int VLEN = 256
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [31:0]     insn_i,
  input  logic [VLEN-1:0] src_a_i,
  input  logic [VLEN-1:0] src_b_i,
  input  logic [VLEN-1:0] acc_i,
  output logic            busy_o,
  output logic            done_o,
  output logic            undef_o,
  output logic [VLEN-1:0] res_o,
  output logic [4:0]      zda_o,
  output logic [4:0]      zn_o,
  output logic [4:0]      zm_o
);
  localparam int NSEG  = VLEN / SEG_W;
  localparam int CNT_W = (NSEG > 1) ? $clog2(NSEG) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(NSEG - 1);

  logic             dec_legal, dec_as, dec_bs;
  logic [4:0]       dec_zda, dec_zn, dec_zm;
  logic             busy_q, done_q, undef_q, as_q, bs_q;
  logic [CNT_W-1:0] seg_q;
  logic [VLEN-1:0]  res_q;
  logic [4:0]       zda_q, zn_q, zm_q;
  logic [SEG_W-1:0] seg_a, seg_b, seg_acc, seg_res;
  logic             accept;

  i8mm_decode u_dec (
    .insn_i    (insn_i),
    .legal_o   (dec_legal),
    .a_signed_o(dec_as),
    .b_signed_o(dec_bs),
    .zda_o     (dec_zda),
    .zn_o      (dec_zn),
    .zm_o      (dec_zm)
  );

  assign seg_a   = src_a_i[int'(seg_q)*SEG_W +: SEG_W];
  assign seg_b   = src_b_i[int'(seg_q)*SEG_W +: SEG_W];
  assign seg_acc = acc_i[int'(seg_q)*SEG_W +: SEG_W];

  i8mm_seg u_seg (
    .a_i       (seg_a),
    .b_i       (seg_b),
    .acc_i     (seg_acc),
    .a_signed_i(as_q),
    .b_signed_i(bs_q),
    .res_o     (seg_res)
  );

  assign accept = start_i && !busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      undef_q <= 1'b0;
      as_q    <= 1'b0;
      bs_q    <= 1'b0;
      seg_q   <= '0;
      res_q   <= '0;
      zda_q   <= '0;
      zn_q    <= '0;
      zm_q    <= '0;
    end else begin
      done_q  <= 1'b0;
      undef_q <= accept && !dec_legal;
      if (accept && dec_legal) begin
        busy_q <= 1'b1;
        seg_q  <= '0;
        as_q   <= dec_as;
        bs_q   <= dec_bs;
        zda_q  <= dec_zda;
        zn_q   <= dec_zn;
        zm_q   <= dec_zm;
      end
      if (busy_q) begin
        res_q[int'(seg_q)*SEG_W +: SEG_W] <= seg_res;
        if (seg_q == LAST) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          seg_q <= seg_q + 1'b1;
        end
      end
    end
  end

  assign busy_o  = busy_q;
  assign done_o  = done_q;
  assign undef_o = undef_q;
  assign res_o   = res_q;
  assign zda_o   = zda_q;
  assign zn_o    = zn_q;
  assign zm_o    = zm_q;

  p_done_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_done_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  p_seg_step_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && $past(busy_q) |-> seg_q == $past(seg_q) + 1'b1);
  p_undef_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    undef_o |-> !busy_o);
  p_rsv_keep_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    undef_o |-> $stable(res_o));
  p_busy_start_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && start_i |=> !undef_o);
  p_flags_excl_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({undef_o, done_o}));
endmodule

// File: tb/tb_i8mm_unit.sv
`timescale 1ns/1ps
module tb_i8mm_unit;
  localparam int VLEN = 256;
  localparam int NSEG = VLEN / 128;
  localparam int NV   = 9;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic            start_i = 1'b0;
  logic [31:0]     insn_i = '0;
  logic [VLEN-1:0] src_a_i = '0, src_b_i = '0, acc_i = '0;
  logic            busy_o, done_o, undef_o;
  logic [VLEN-1:0] res_o;
  logic [4:0]      zda_o, zn_o, zm_o;

  int n_chk = 0, n_bad = 0;

  always #2.5 clk_i = ~clk_i;

  i8mm_unit #(.VLEN(VLEN)) dut (.*);

  // stimulus words and expected undefined flag
  localparam logic [31:0] T_INSN [NV] = '{
    32'h410798A3, 32'h4182983F, 32'h41DE9A8A, 32'h41409800, 32'h41209800,
    32'h41009C00, 32'h61009800, 32'h41009800, 32'h4100D800};
  localparam logic T_UND [NV] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1};

  task automatic chk(input bit ok, input string req, input logic [VLEN-1:0] act,
                     input logic [VLEN-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [VLEN-1:0] gen(input logic [31:0] seed);
    logic [VLEN-1:0] v;
    for (int w = 0; w < VLEN/32; w++) begin
      logic [31:0] x;
      x = seed * 32'h9E3779B1 + w * 32'h85EBCA6B;
      x = x ^ (x >> 15);
      x = x * 32'h2C1B3C6D;
      v[w*32 +: 32] = x ^ (x >> 13);
    end
    return v;
  endfunction

  function automatic logic [VLEN-1:0] mdl(input logic [1:0] v, input logic [VLEN-1:0] a,
                                          input logic [VLEN-1:0] b, input logic [VLEN-1:0] c);
    logic [VLEN-1:0] r;
    for (int s = 0; s < NSEG; s++)
      for (int i = 0; i < 2; i++)
        for (int j = 0; j < 2; j++) begin
          logic [31:0] sum;
          sum = c[s*128 + 32*(2*i+j) +: 32];
          for (int k = 0; k < 8; k++) begin
            logic [7:0]  x, y;
            logic [31:0] ex, ey;
            x = a[s*128 + 8*(8*i+k) +: 8];
            y = b[s*128 + 8*(8*j+k) +: 8];
            ex = (v == 2'b00) ? {{24{x[7]}}, x} : {24'b0, x};
            ey = (v == 2'b11) ? {24'b0, y} : {{24{y[7]}}, y};
            sum = sum + ex * ey;
          end
          r[s*128 + 32*(2*i+j) +: 32] = sum;
        end
    return r;
  endfunction

  task automatic run(input logic [31:0] insn, input logic [VLEN-1:0] a, input logic [VLEN-1:0] b,
                     input logic [VLEN-1:0] c, output int lat, output bit und);
    @(negedge clk_i);
    insn_i = insn; src_a_i = a; src_b_i = b; acc_i = c; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    und = undef_o;
    lat = 0;
    if (!und) begin
      while (!done_o && lat < 100) begin
        @(negedge clk_i);
        lat++;
      end
    end
  endtask

  function automatic string vreq(input logic [1:0] v);
    return (v == 2'b00) ? "R3" : (v == 2'b10) ? "R4" : "R5";
  endfunction

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int lat; bit und;
    logic [VLEN-1:0] a, b, c, prev, exp;
    repeat (3) @(negedge clk_i);
    // R11 reset state
    chk(!busy_o && !done_o && !undef_o, "R11 flags", {busy_o, done_o, undef_o}, 0);
    chk(res_o == '0, "R11 result", res_o, '0);
    rst_ni = 1'b1;

    for (int t = 0; t < NV; t++) begin
      a = gen(t * 7 + 1); b = gen(t * 7 + 2); c = gen(t * 7 + 3);
      prev = res_o;
      run(T_INSN[t], a, b, c, lat, und);
      chk(und == T_UND[t], "R1 undef flag", und, T_UND[t]);
      if (T_UND[t]) begin
        chk(!busy_o, "R1 no busy", busy_o, 0);
        chk(res_o == prev, (T_INSN[t][23:22] == 2'b01) ? "R6 unchanged" : "R1 unchanged", res_o, prev);
        @(negedge clk_i);
        chk(!undef_o, "R1 undef one cycle", undef_o, 0);
      end else begin
        exp = mdl(T_INSN[t][23:22], a, b, c);
        chk(lat == NSEG, "R9 latency", lat, NSEG);
        chk(res_o == exp, vreq(T_INSN[t][23:22]), res_o, exp);
        chk({zda_o, zn_o, zm_o} == {T_INSN[t][4:0], T_INSN[t][9:5], T_INSN[t][20:16]},
            "R2 indices", {zda_o, zn_o, zm_o}, {T_INSN[t][4:0], T_INSN[t][9:5], T_INSN[t][20:16]});
        @(negedge clk_i);
        chk(!done_o, "R9 done one cycle", done_o, 0);
      end
    end

    // R7 element placement: A row1 k2 = 1, B row0 k2 = 1 -> segment 0 lane 2 = 1
    a = '0; b = '0; c = '0;
    a[8*(8+2) +: 8] = 8'd1;
    b[8*2 +: 8] = 8'd1;
    exp = '0; exp[32*2 +: 32] = 32'd1;
    run(32'h41009800, a, b, c, lat, und);
    chk(res_o == exp, "R7 lane placement", res_o, exp);

    // R8 wrap, signed: -128*-128*8 = 131072 on 0xFFFFFFFF -> 0x0001FFFF
    a = {(VLEN/8){8'h80}}; b = a; c = {(VLEN/32){32'hFFFFFFFF}};
    exp = {(VLEN/32){32'h0001FFFF}};
    run(32'h41009800, a, b, c, lat, und);
    chk(res_o == exp, "R8 signed wrap", res_o, exp);

    // R8/R5 wrap, unsigned: 255*255*8 = 0x7F008 on 0xFFFF0000 -> 0x0006F008
    a = {(VLEN/8){8'hFF}}; b = a; c = {(VLEN/32){32'hFFFF0000}};
    exp = {(VLEN/32){32'h0006F008}};
    run(32'h41C09800, a, b, c, lat, und);
    chk(res_o == exp, "R8 unsigned wrap", res_o, exp);

    // R4 mixed: A=0xFF (255) x B=0xFF (-1) * 8 = -2040 -> 0xFFFFF808
    c = '0;
    exp = {(VLEN/32){32'hFFFFF808}};
    run(32'h41809800, a, b, c, lat, und);
    chk(res_o == exp, "R4 mixed extremes", res_o, exp);

    // R10 start while busy ignored
    a = gen(101); b = gen(102); c = gen(103);
    exp = mdl(2'b00, a, b, c);
    @(negedge clk_i);
    insn_i = 32'h410798A3; src_a_i = a; src_b_i = b; acc_i = c; start_i = 1'b1;
    @(negedge clk_i);
    insn_i = 32'h41C1F8A5; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    chk(!undef_o, "R10 no undef", undef_o, 0);
    lat = 1;
    while (!done_o && lat < 100) begin
      @(negedge clk_i);
      lat++;
    end
    chk(lat == NSEG, "R10 latency", lat, NSEG);
    chk(res_o == exp, "R10 result kept", res_o, exp);
    chk({zda_o, zn_o, zm_o} == {5'd3, 5'd5, 5'd7}, "R10 indices kept", {zda_o, zn_o, zm_o}, {5'd3, 5'd5, 5'd7});

    // R6 reserved after a result: result still unchanged
    prev = res_o;
    run(32'h414798A3, gen(5), gen(6), gen(7), lat, und);
    chk(und, "R6 undef", und, 1);
    chk(res_o == prev && zda_o == 5'd3, "R6 state kept", res_o, prev);

    repeat (2) @(negedge clk_i);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule